// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks a single processor's reservation for load-exclusive / store-exclusive sequences. When a load-exclusive is seen, the monitor enters its exclusive state. It also records which address granule was touched. A later store-exclusive to the same granule is let through to memory and reports status 0. Otherwise the store is suppressed and reports status 1. Every store-exclusive returns the monitor to its open state, whether it succeeds or fails.

Software can drop a reservation in two ways. A clear-exclusive operation on the access bus drops it, and so does a separate clear line that exception-return logic pulses when control goes back to pre-empted code. If neither is used across a context switch, a stale reservation survives and a later store-exclusive succeeds when it should not. The monitor reproduces that hazard faithfully, because the clearing discipline belongs to software. Ordinary stores pass through to the memory write port and leave the reservation alone.

All results are registered and appear one cycle after the access is accepted.

Top module: `excl_monitor`

## Requirements
- R1: After reset, mon_exclusive, mem_we, stx_done and stx_status are all 0 (open state).
- R2: An accepted load-exclusive (op_code 3'd2) with exc_ret_clr low sets mon_exclusive the next cycle. It also records op_addr with its low GRAN_LOG2 bits dropped as the tag.
- R3: An accepted clear-exclusive (op_code 3'd4) makes mon_exclusive 0 the next cycle.
- R4: An accepted store-exclusive (op_code 3'd3) makes mon_exclusive 0 the next cycle whatever its result, including one to an unrelated address.
- R5: A store-exclusive accepted while exclusive, to the tagged granule, gives mem_we=1 for that one result cycle with mem_addr/mem_wdata equal to the request, stx_done=1 and stx_status=0.
- R6: A store-exclusive accepted while open, or to another granule, gives mem_we=0, stx_done=1 and stx_status=1.
- R7: exc_ret_clr high at a clock edge makes mon_exclusive 0 the next cycle, overriding a load-exclusive in the same cycle. A store-exclusive in that cycle is still judged on the state held before the edge.
- R8: An accepted plain store (op_code 3'd1) gives mem_we=1 the next cycle with the request's address and data, and leaves mon_exclusive unchanged. Plain loads (3'd0) and the unused codes 3'd5 to 3'd7 change nothing and write nothing.
- R9: Without a clear between a load-exclusive and a store-exclusive to its granule, the store-exclusive succeeds regardless of intervening plain stores or idle cycles.
- R10: Granule matching ignores the low GRAN_LOG2 address bits, so a different offset within the same granule matches and the adjacent granule does not.
- R11: stx_done is high for exactly the cycle after each accepted store-exclusive, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Access strobe |
| op_code | input | 3 | Access kind: 0 load, 1 store, 2 load-excl, 3 store-excl, 4 clear-excl |
| op_addr | input | AW | Access byte address |
| op_wdata | input | DW | Store data |
| exc_ret_clr | input | 1 | Exception-return clear of the reservation |
| mem_we | output | 1 | Gated memory write enable |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| stx_done | output | 1 | Store-exclusive result valid |
| stx_status | output | 1 | 0 success, 1 failure |
| mon_exclusive | output | 1 | Monitor state: 1 exclusive, 0 open |

## Verification
The hardest situation to reach is an exclusive state that is still alive across a would-be context switch. That state is needed to show the stale-reservation success and its cure by the exception-return clear. The stimulus builds it on purpose: a load-exclusive, then plain stores and idle cycles, then a store-exclusive. It repeats the same sequence with exc_ret_clr pulsed in the gap. It also places a clear in the same cycle as a load-exclusive and as a store-exclusive, to show the precedence. A long random phase, with addresses drawn from a few neighbouring granules, then mixes all operations so that matching and mismatching tags both occur often.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          exc_ret_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          stx_done,
  output logic          stx_status,
  output logic          mon_exclusive
);
  localparam int TW = AW - GRAN_LOG2;

  localparam logic [2:0] OP_ST   = 3'd1;
  localparam logic [2:0] OP_LDX  = 3'd2;
  localparam logic [2:0] OP_STX  = 3'd3;
  localparam logic [2:0] OP_CLRX = 3'd4;

  typedef enum logic {MON_OPEN = 1'b0, MON_EXCL = 1'b1} mon_state_e;

  mon_state_e    state_q, state_d;
  logic [TW-1:0] tag_q;

  logic [TW-1:0] req_tag;
  logic is_st, is_ldx, is_stx, is_clrx, hit;

  assign req_tag = op_addr[AW-1:GRAN_LOG2];
  assign is_st   = op_valid && (op_code == OP_ST);
  assign is_ldx  = op_valid && (op_code == OP_LDX);
  assign is_stx  = op_valid && (op_code == OP_STX);
  assign is_clrx = op_valid && (op_code == OP_CLRX);
  assign hit     = (state_q == MON_EXCL) && (tag_q == req_tag);

  always_comb begin
    state_d = state_q;
    if (is_ldx)
      state_d = MON_EXCL;
    if (is_stx || is_clrx || exc_ret_clr)
      state_d = MON_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= MON_OPEN;
      tag_q      <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      stx_done   <= 1'b0;
      stx_status <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (is_ldx)
        tag_q <= req_tag;
      mem_we     <= is_st || (is_stx && hit);
      stx_done   <= is_stx;
      stx_status <= is_stx && !hit;
      if (is_st || is_stx) begin
        mem_addr  <= op_addr;
        mem_wdata <= op_wdata;
      end
    end
  end

  assign mon_exclusive = (state_q == MON_EXCL);
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          exc_ret_clr,
  input logic          mem_we,
  input logic          stx_done,
  input logic          stx_status,
  input logic          mon_exclusive
);
  logic ldx, stx, st;
  assign ldx = op_valid && op_code == 3'd2;
  assign stx = op_valid && op_code == 3'd3;
  assign st  = op_valid && op_code == 3'd1;

  AST_EXCL_AFTER_LDX: assert property (@(posedge clk) disable iff (!rst_n)
    ldx && !exc_ret_clr |=> mon_exclusive); // R2
  AST_OPEN_AFTER_CLRX: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd4 |=> !mon_exclusive); // R3
  AST_OPEN_AFTER_STX: assert property (@(posedge clk) disable iff (!rst_n)
    stx |=> !mon_exclusive); // R4
  AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    stx_done && !stx_status |-> mem_we); // R5
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stx_done && stx_status |-> !mem_we); // R6
  AST_FAIL_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    stx && !mon_exclusive |=> stx_done && stx_status); // R6
  AST_EXC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret_clr |=> !mon_exclusive); // R7
  AST_STORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    st && !exc_ret_clr |=> $stable(mon_exclusive) && mem_we); // R8
  AST_DONE_FOLLOWS_STX: assert property (@(posedge clk) disable iff (!rst_n)
    stx |=> stx_done); // R11
  AST_DONE_ONLY_STX: assert property (@(posedge clk) disable iff (!rst_n)
    !stx |=> !stx_done); // R11
endmodule

bind excl_monitor excl_monitor_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .exc_ret_clr(exc_ret_clr), .mem_we(mem_we), .stx_done(stx_done),
  .stx_status(stx_status), .mon_exclusive(mon_exclusive)
);

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int G  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic exc_ret_clr = 1'b0;
  logic mem_we, stx_done, stx_status, mon_exclusive;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.AW(AW), .DW(DW), .GRAN_LOG2(G)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .exc_ret_clr(exc_ret_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stx_done(stx_done), .stx_status(stx_status), .mon_exclusive(mon_exclusive)
  );

  // behavioural reference
  bit          m_held = 0;
  longint      m_gran = 0;
  bit          e_we = 0, e_done = 0, e_stat = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;
  string       req_state = "R1", req_out = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_held = 0; e_we = 0; e_done = 0; e_stat = 0; e_addr = '0; e_data = '0;
      req_state = "R1"; req_out = "R1";
    end else begin
      bit ok;
      longint g;
      g = longint'(op_addr) / (1 << G);
      ok = m_held && (g == m_gran);
      e_done = 0; e_stat = 0; e_we = 0;
      req_out = "R8"; req_state = "R8";
      if (op_valid) begin
        case (op_code)
          3'd1: begin e_we = 1; e_addr = op_addr; e_data = op_wdata; end
          3'd2: begin m_held = 1; m_gran = g; req_state = "R2"; end
          3'd3: begin
            e_done = 1; e_stat = !ok; e_we = ok;
            e_addr = op_addr; e_data = op_wdata;
            m_held = 0; req_state = "R4"; req_out = ok ? "R5" : "R6";
          end
          3'd4: begin m_held = 0; req_state = "R3"; end
          default: ;
        endcase
      end
      if (exc_ret_clr) begin m_held = 0; req_state = "R7"; end
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(mon_exclusive == m_held, req_state, "state", mon_exclusive, m_held);
      chk(mem_we == e_we, req_out, "mem_we", mem_we, e_we);
      chk(stx_done == e_done, "R11", "stx_done", stx_done, e_done);
      if (e_done) chk(stx_status == e_stat, req_out, "stx_status", stx_status, e_stat);
      if (e_we) begin
        chk(mem_addr == e_addr, req_out, "mem_addr", mem_addr, e_addr);
        chk(mem_wdata == e_data, req_out, "mem_wdata", mem_wdata, e_data);
      end
    end
  end

  task automatic op(input logic [2:0] c, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input bit clr = 0);
    @(negedge clk);
    op_valid = 1; op_code = c; op_addr = a; op_wdata = d; exc_ret_clr = clr;
    @(negedge clk);
    op_valid = 0; op_code = 3'd0; exc_ret_clr = 0;
  endtask

  task automatic clr_only();
    @(negedge clk); exc_ret_clr = 1;
    @(negedge clk); exc_ret_clr = 0;
  endtask

  // directed result check, sampled at the negedge right after the op's edge
  task automatic stx_expect(input logic [AW-1:0] a, input bit pass, input string req);
    @(negedge clk);
    op_valid = 1; op_code = 3'd3; op_addr = a; op_wdata = 32'hA5A5_0000 ^ a;
    @(negedge clk);
    op_valid = 0; op_code = 3'd0;
    chk(stx_done && (stx_status == !pass), req, "directed stx status", stx_status, !pass);
    chk(mem_we == pass, req, "directed stx write", mem_we, pass);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mon_exclusive && !mem_we && !stx_done && !stx_status, "R1", "reset outputs",
        {mon_exclusive, mem_we, stx_done, stx_status}, 0);
    rst_n = 1;
    @(negedge clk);
    // R5 basic success, then R6/R4 repeat fails
    op(3'd2, 32'h100, 0);
    stx_expect(32'h100, 1, "R5");
    stx_expect(32'h100, 0, "R4");
    // R4 dummy address clears
    op(3'd2, 32'h200, 0);
    stx_expect(32'h900, 0, "R6");
    stx_expect(32'h200, 0, "R4");
    // R3 clear-exclusive
    op(3'd2, 32'h300, 0);
    op(3'd4, 32'h0, 0);
    stx_expect(32'h300, 0, "R3");
    // R9 stale reservation survives stores and idle
    op(3'd2, 32'h400, 0);
    op(3'd1, 32'h404, 32'h1234);
    op(3'd1, 32'h800, 32'h5678);
    repeat (4) @(negedge clk);
    stx_expect(32'h400, 1, "R9");
    // R7 exception-return clear cures it
    op(3'd2, 32'h400, 0);
    clr_only();
    stx_expect(32'h400, 0, "R7");
    op(3'd2, 32'h500, 0, 1);
    chk(!mon_exclusive, "R7", "clear beats load-excl", mon_exclusive, 0);
    op(3'd2, 32'h500, 0);
    @(negedge clk);
    op_valid = 1; op_code = 3'd3; op_addr = 32'h500; exc_ret_clr = 1;
    @(negedge clk);
    op_valid = 0; exc_ret_clr = 0;
    chk(!stx_status && mem_we, "R7", "stx judged on prior state", stx_status, 0);
    // R10 granule matching
    op(3'd2, 32'h600, 0);
    stx_expect(32'h605, 1, "R10");
    op(3'd2, 32'h600, 0);
    stx_expect(32'h608, 0, "R10");
    // R8 unused codes and plain load
    op(3'd2, 32'h700, 0);
    op(3'd5, 32'h700, 0);
    op(3'd6, 32'h700, 0);
    op(3'd7, 32'h700, 0);
    op(3'd0, 32'h700, 0);
    chk(mon_exclusive && !mem_we, "R8", "no-op codes", mon_exclusive, 1);
    stx_expect(32'h700, 1, "R8");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      op_valid    = ($urandom_range(0, 3) != 0);
      op_code     = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) op_code = 3'($urandom_range(2, 3));
      op_addr     = 32'h1000 + 32'($urandom_range(0, 31));
      op_wdata    = $urandom;
      exc_ret_clr = ($urandom_range(0, 15) == 0);
    end
    @(negedge clk);
    op_valid = 0; exc_ret_clr = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule